// File: doc/BRIEF.md
# Peripheral-to-fabric interrupt combiner

This block collects 43 level-sensitive, active-high interrupt lines raised by processor-side peripherals and folds them onto 16 interrupt outputs toward programmable logic. Each output has its own small combining circuit. A dedicated peripheral line always feeds that circuit. On top of it comes one of two alternative source groups, and a per-output mode bit picks which group that is. The mode bits live in a 16-bit register that software reaches through a plain synchronous write/read port.

Two special lines skip the combiner entirely: a non-maskable watchdog interrupt and a communication-block interrupt are copied straight to their own outputs. Four SMBus alert/suspend lines that belong to two I2C controllers are accepted at the input but have no path to any output. The routing of peripheral lines to dedicated, group-0 and group-1 slots is a fixed table computed inside the design. Any slot without a source is tied low.

Top module: `irq_fold_top`

## Requirements
- R1: The path from `periph_irq` to `fab_irq` is combinational: a change on an input shows on the outputs in the same cycle with no clock edge, and an output drops as soon as every line it draws on is low.
- R2: `fab_irq[k]` is high whenever `periph_irq[k]` (its dedicated line, k = 0..15) is high, whatever the mode bit of output k.
- R3: With mode bit k at 0 (group 0), `fab_irq[k]` is the OR of `periph_irq[k]` and, for k < 12, `periph_irq[16+k]`; the group-1 line of that output has no effect.
- R4: With mode bit k at 1 (group 1), `fab_irq[k]` is the OR of `periph_irq[k]` and, for k < 11, `periph_irq[28+k]`; the group-0 line of that output has no effect.
- R5: Slots with no source are tied low: the group-0 slot of outputs 12..15 and the group-1 slot of outputs 11..15 contribute nothing in either mode.
- R6: Inputs `periph_irq[42:39]` (the SMBus alert/suspend lines) never affect any `fab_irq` bit.
- R7: The mode register is 16 bits, bit k selecting the group for output k. It resets to 0 (all group 0). A write with `reg_wr` high and `reg_addr` = 0 loads `reg_wdata` at the rising edge. Writes to other addresses change nothing. `reg_rdata` shows the register at address 0 and reads 0 at any other address.
- R8: `nmi_out` equals `wdog_nmi_in` and `comm_irq_out` equals `comm_irq_in` at all times, independent of the mode register and of `periph_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| periph_irq | input | 43 | Peripheral interrupt lines, level, active high |
| wdog_nmi_in | input | 1 | Watchdog non-maskable interrupt |
| comm_irq_in | input | 1 | Communication-block interrupt |
| reg_addr | input | 4 | Register port address |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| fab_irq | output | 16 | Combined interrupts toward programmable logic |
| nmi_out | output | 1 | Watchdog interrupt copied through |
| comm_irq_out | output | 1 | Communication interrupt copied through |

## Verification
The interrupt outputs, the two copied lines and the read data follow their inputs with zero cycles of latency. The bench drives every input on a falling edge and samples one nanosecond later, with no clock edge in between. A mode-register write is captured at the next rising edge. The bench therefore raises `reg_wr` on a falling edge, drops it on the following falling edge, and then checks both `reg_rdata` and the outputs that the new mode bits steer. After reset is released, the bench waits three edges for the internal synchronizer before it writes.

// File: rtl/irq_fold_pkg.sv
package irq_fold_pkg;
  localparam int N_IN      = 43;
  localparam int N_OUT     = 16;
  localparam int GRP_SLOTS = 1;
  localparam int ADDR_W    = 4;
  // routing layout: dedicated lines first, then group 0, then group 1
  localparam int G0_BASE   = N_OUT;
  localparam int G0_COUNT  = 12;
  localparam int G1_BASE   = G0_BASE + G0_COUNT * GRP_SLOTS;
  localparam int G1_COUNT  = 11;
  localparam int ROUTED    = G1_BASE + G1_COUNT * GRP_SLOTS;
  localparam logic [ADDR_W-1:0] MODE_ADDR = '0;

  // returns the input index feeding a group slot, or -1 for an empty slot
  function automatic int grp_src(input int grp, input int row, input int slot);
    int base;
    int cnt;
    base = (grp == 0) ? G0_BASE : G1_BASE;
    cnt  = (grp == 0) ? G0_COUNT : G1_COUNT;
    if (row < cnt) return base + row * GRP_SLOTS + slot;
    return -1;
  endfunction
endpackage

// File: rtl/irq_mode_reg.sv
module irq_mode_reg
  import irq_fold_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [N_OUT-1:0]  wdata_i,
  output logic [N_OUT-1:0]  rdata_o,
  output logic [N_OUT-1:0]  mode_o
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             hit;
  logic             wr_en;
  logic [N_OUT-1:0] mode_q;
  logic [N_OUT-1:0] mode_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign hit   = (addr_i == MODE_ADDR);
  assign wr_en = wr_i & hit;

  always_comb begin
    mode_d = mode_q;
    if (wr_en) mode_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mode_q <= '0;
    else if (wr_en)   mode_q <= mode_d;
  end

  assign mode_o  = mode_q;
  assign rdata_o = hit ? mode_q : '0;

  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_i && addr_i == MODE_ADDR) |=> (mode_o == $past(wdata_i))); // R7
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(wr_i && addr_i == MODE_ADDR) |=> $stable(mode_o)); // R7
endmodule

// File: rtl/irq_row.sv
module irq_row
  import irq_fold_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_i,
  input  logic                 ded_i,
  input  logic [GRP_SLOTS-1:0] g0_i,
  input  logic [GRP_SLOTS-1:0] g1_i,
  output logic                 irq_o
);
  logic grp_hit;

  always_comb begin
    if (mode_i) grp_hit = |g1_i;
    else        grp_hit = |g0_i;
    irq_o = ded_i | grp_hit;
  end

  AST_DED_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    ded_i |-> irq_o); // R2
  AST_G0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && !ded_i && g0_i == '0) |-> !irq_o); // R3
  AST_G1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && !ded_i && g1_i == '0) |-> !irq_o); // R4
endmodule

// File: rtl/irq_fold_top.sv
module irq_fold_top
  import irq_fold_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   periph_irq,
  input  logic              wdog_nmi_in,
  input  logic              comm_irq_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [N_OUT-1:0]  reg_wdata,
  output logic [N_OUT-1:0]  reg_rdata,
  output logic [N_OUT-1:0]  fab_irq,
  output logic              nmi_out,
  output logic              comm_irq_out
);
  logic [N_OUT-1:0] mode;
  logic             lines_unused;

  // SMBus alert/suspend lines above the routed range reach no output (R6)
  assign lines_unused = ^periph_irq[N_IN-1:ROUTED];

  irq_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (reg_addr),
    .wr_i    (reg_wr),
    .wdata_i (reg_wdata),
    .rdata_o (reg_rdata),
    .mode_o  (mode)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_row
    logic [GRP_SLOTS-1:0] g0;
    logic [GRP_SLOTS-1:0] g1;
    for (genvar s = 0; s < GRP_SLOTS; s++) begin : g_slot
      if (grp_src(0, k, s) >= 0) begin : g_g0_on
        assign g0[s] = periph_irq[grp_src(0, k, s)];
      end else begin : g_g0_off
        assign g0[s] = 1'b0; // R5
      end
      if (grp_src(1, k, s) >= 0) begin : g_g1_on
        assign g1[s] = periph_irq[grp_src(1, k, s)];
      end else begin : g_g1_off
        assign g1[s] = 1'b0; // R5
      end
    end
    irq_row u_row (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (mode[k]),
      .ded_i  (periph_irq[k]),
      .g0_i   (g0),
      .g1_i   (g1),
      .irq_o  (fab_irq[k])
    );
  end

  // bypass lines, outside the combiner (R8)
  assign nmi_out      = wdog_nmi_in;
  assign comm_irq_out = comm_irq_in;

  AST_NO_SMBUS: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_irq[ROUTED-1:0] == '0) |-> (fab_irq == '0)); // R6
endmodule

// File: tb/sim_irq_fold_top.sv
`timescale 1ns/1ps
module sim_irq_fold_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [42:0] periph_irq;
  logic        wdog_nmi_in, comm_irq_in;
  logic [3:0]  reg_addr;
  logic        reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [15:0] fab_irq;
  logic        nmi_out, comm_irq_out;
  int          total = 0;
  int          bad = 0;
  int          cyc = 0;

  always #4 clk = ~clk;

  irq_fold_top u0 (
    .clk(clk), .rst_n(rst_n), .periph_irq(periph_irq),
    .wdog_nmi_in(wdog_nmi_in), .comm_irq_in(comm_irq_in),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fab_irq(fab_irq),
    .nmi_out(nmi_out), .comm_irq_out(comm_irq_out)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // expected outputs from the requirement text (R2..R5)
  function automatic logic [15:0] expect_out(input logic [42:0] v, input logic [15:0] m);
    logic [15:0] r;
    for (int k = 0; k < 16; k++) begin
      r[k] = v[k];
      if (!m[k] && k < 12) r[k] = r[k] | v[16+k];
      if ( m[k] && k < 11) r[k] = r[k] | v[28+k];
    end
    return r;
  endfunction

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [42:0] v);
    @(negedge clk);
    periph_irq = v;
    #1;
  endtask

  task automatic write_mode(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 4'd0;
    #1;
  endtask

  task automatic t_reset();
    check16("R7 reset mode", reg_rdata, 16'h0000);
    apply(43'd0);
    check16("R1 idle outputs", fab_irq, 16'h0000);
  endtask

  task automatic t_dedicated();
    apply(43'h0000000A5C3);
    check16("R2 dedicated mode0", fab_irq, 16'hA5C3);
    write_mode(4'd0, 16'hFFFF);
    apply(43'h0000000FFFF);
    check16("R2 dedicated mode1", fab_irq, 16'hFFFF);
    write_mode(4'd0, 16'h0000);
  endtask

  task automatic t_mode0();
    logic [42:0] v;
    v = '0;
    v[16+3] = 1'b1; v[16+11] = 1'b1; v[28+5] = 1'b1;
    apply(v);
    check16("R3 group0 active, group1 ignored", fab_irq, expect_out(v, 16'h0000));
    check16("R3 literal", fab_irq, 16'h0808);
    apply(43'd0);
    check16("R1 deassert immediate", fab_irq, 16'h0000);
  endtask

  task automatic t_mode1();
    logic [42:0] v;
    write_mode(4'd0, 16'h0423);
    check16("R7 readback", reg_rdata, 16'h0423);
    v = '0;
    v[16+0] = 1'b1; v[16+1] = 1'b1; v[16+2] = 1'b1;
    v[28+5] = 1'b1; v[28+10] = 1'b1; v[28+6] = 1'b1;
    apply(v);
    check16("R4 mixed modes", fab_irq, expect_out(v, 16'h0423));
    check16("R4 literal", fab_irq, 16'h0424);
  endtask

  task automatic t_empty();
    logic [42:0] v;
    write_mode(4'd0, 16'hF800);
    v = '0;
    for (int i = 16; i < 39; i++) v[i] = 1'b1;
    apply(v);
    check16("R5 empty slots mode1 upper", fab_irq, 16'h07FF);
    write_mode(4'd0, 16'h0000);
    apply(v);
    check16("R5 empty slots mode0", fab_irq, 16'h0FFF);
  endtask

  task automatic t_smbus();
    apply(43'h78000000000);
    check16("R6 smbus mode0", fab_irq, 16'h0000);
    write_mode(4'd0, 16'hFFFF);
    apply(43'h78000000000);
    check16("R6 smbus mode1", fab_irq, 16'h0000);
    apply(43'd0);
  endtask

  task automatic t_reg();
    write_mode(4'd0, 16'h1234);
    write_mode(4'd5, 16'hBEEF);
    check16("R7 other address write ignored", reg_rdata, 16'h1234);
    @(negedge clk); reg_addr = 4'd5; #1;
    check16("R7 other address reads zero", reg_rdata, 16'h0000);
    @(negedge clk); reg_addr = 4'd0; #1;
  endtask

  task automatic t_pass();
    logic [15:0] pair;
    write_mode(4'd0, 16'hAAAA);
    @(negedge clk); wdog_nmi_in = 1'b1; comm_irq_in = 1'b0; periph_irq = '0; #1;
    pair = {14'd0, nmi_out, comm_irq_out};
    check16("R8 nmi through", pair, 16'h0002);
    @(negedge clk); wdog_nmi_in = 1'b0; comm_irq_in = 1'b1; periph_irq = '1; #1;
    pair = {14'd0, nmi_out, comm_irq_out};
    check16("R8 comm through", pair, 16'h0001);
    check16("R8 bypass does not enter combiner", fab_irq, 16'hFFFF);
  endtask

  initial begin
    rst_n = 1'b0; periph_irq = '0; wdog_nmi_in = 1'b0; comm_irq_in = 1'b0;
    reg_addr = 4'd0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    t_dedicated();
    t_mode0();
    t_mode1();
    t_empty();
    t_smbus();
    t_reg();
    t_pass();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule